// File: doc/BRIEF.md
# DMA channel run-state controller

This block is the control state machine of one descriptor-driven DMA channel. Software writes a small control word holding an enable bit, a continue bit, a restart-from-start bit and a pointer-type bit. The controller turns each write, together with completion and fault strobes from the transfer engine, into a run state and into one-cycle requests for the descriptor sequencer. It does not move data or compute addresses. It only decides whether the sequencer reloads its pointers from the start addresses or steps the source pointer to the next descriptor.

Each completed descriptor carries a 2-bit command. Stop ends the run. Halt parks the channel in a paused state, from which software resumes with the continue bit. Any other value makes the channel go on to the next descriptor. In register-pointer mode there is only one descriptor, so every completion ends the run. All outputs are registered. A write or a strobe sampled at one clock edge shows its effect on the outputs after that edge.

Top module: `dmac_run_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `state_code` is 0 and `chan_en`, `cont_pend`, `start_req`, `adv_req`, `pause_evt` and `done_evt` are all 0.
- R2: `state_code` reads 0 for disabled, 1 for enabled and 2 for paused. While the error flag is set it reads 3. A write with the enable bit at 1 clears the error flag.
- R3: A write with enable at 1 while disabled, with or without the error flag, gives a one-cycle `start_req` and moves the channel to enabled (1).
- R4: A write with enable at 1 and continue at 1 while paused resumes the channel to enabled and clears `cont_pend`. With the restart bit at 1 it raises `start_req`. With the restart bit at 0 it raises `adv_req`. Exactly one of the two is raised.
- R5: A write with enable at 1 and continue at 0 while paused leaves the channel paused and raises no request.
- R6: A write with enable at 0 and continue at 1 while paused moves the channel to disabled without a request. `cont_pend` stays 1.
- R7: Every completion while enabled gives a one-cycle `done_evt`. If the pointer-type bit is 0 (register descriptors) or the command is 2 (stop), `chan_en` clears and the channel goes to disabled.
- R8: With pointer-type 1 (memory descriptors), a completion with command 1 (halt) moves the channel to paused (2) and gives a one-cycle `pause_evt`.
- R9: With pointer-type 1, a completion with command 0 or 3 gives a one-cycle `adv_req` and the channel stays enabled.
- R10: A descriptor-fetch error while enabled forces the channel to disabled and sets the error flag, so `state_code` reads 3. The error takes precedence over a completion in the same cycle.
- R11: Completion and error strobes are ignored when the channel is not enabled, and in a cycle in which a control write occurs. Ignored strobes produce no event and no request, and leave the state unchanged.
- R12: A write with enable at 1 while already enabled raises no request and keeps the channel enabled. Each write causes at most one state transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | One-cycle control-word write strobe |
| cfg_en | input | 1 | Written enable bit |
| cfg_cont | input | 1 | Written continue bit |
| cfg_from_start | input | 1 | Written restart-from-start bit (1 = reload pointers on resume) |
| cfg_mem_ptr | input | 1 | Written pointer-type bit (0 = register, 1 = memory descriptors) |
| desc_done | input | 1 | Descriptor completion strobe from the transfer engine |
| desc_cmd | input | CMD_W | Command field of the completed descriptor (1 halt, 2 stop) |
| fetch_err | input | 1 | Descriptor-fetch error strobe |
| state_code | output | 2 | Run state: 0 disabled, 1 enabled, 2 paused, 3 error |
| chan_en | output | 1 | Current enable bit |
| cont_pend | output | 1 | Current continue bit |
| start_req | output | 1 | Pulse: reload descriptor pointers from start addresses |
| adv_req | output | 1 | Pulse: step the source pointer to the next descriptor |
| pause_evt | output | 1 | Pulse: channel paused by a halt command |
| done_evt | output | 1 | Pulse: a descriptor completed |

## Verification
The properties assume that `desc_cmd` is valid whenever `desc_done` is high. They also assume that every strobe is a single-cycle pulse sampled on one clock edge. The properties must hold even when the engine strobes arrive in states where they are ignored. The stimulus drives each write or strobe for exactly one cycle and returns all inputs to idle in between. It also deliberately places completions and errors in the disabled state, in the error state and in the same cycle as a write, so that the ignore rules are exercised.

// File: rtl/dmac_pkg.sv
// Shared types for the DMA channel run-state controller.
// Assumes a 2-bit state code in which value 3 is reserved for the error view.
package dmac_pkg;
    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        RS_OFF  = 2'd0,
        RS_RUN  = 2'd1,
        RS_HOLD = 2'd2
    } run_state_e;

    localparam logic [STATE_W-1:0] ERR_CODE = 2'd3;
endpackage

// File: rtl/dmac_cfg_bits.sv
// Control-bit holder: keeps enable, continue, restart and pointer-type bits.
// It presents the effective value of each bit, which is the written value in the
// cycle of a write, so that the state machine acts on a write in that same cycle.
// Assumes the clear requests from the state machine are based on effective values.
module dmac_cfg_bits (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wr_en,
    input  logic wr_cont,
    input  logic wr_from_start,
    input  logic wr_mem_ptr,
    input  logic clr_en,
    input  logic clr_cont,
    output logic eff_en,
    output logic eff_cont,
    output logic eff_from_start,
    output logic eff_mem_ptr,
    output logic en_q,
    output logic cont_q
);
    logic from_start_q;
    logic mem_ptr_q;

    // Select the written value in a write cycle, else the stored one.
    always_comb begin
        eff_en         = wr ? wr_en         : en_q;
        eff_cont       = wr ? wr_cont       : cont_q;
        eff_from_start = wr ? wr_from_start : from_start_q;
        eff_mem_ptr    = wr ? wr_mem_ptr    : mem_ptr_q;
    end

    // Store the effective bits, applying self-clears from the state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q         <= 1'b0;
            cont_q       <= 1'b0;
            from_start_q <= 1'b0;
            mem_ptr_q    <= 1'b0;
        end else begin
            en_q         <= eff_en & ~clr_en;
            cont_q       <= eff_cont & ~clr_cont;
            from_start_q <= eff_from_start;
            mem_ptr_q    <= eff_mem_ptr;
        end
    end
endmodule

// File: rtl/dmac_run_fsm.sv
// Run-state machine: decides the next run state, the error flag, the bit clears
// and the request and event bits for the following cycle.
// A control write takes priority over engine strobes in the same cycle.
// Engine strobes count only while enabled, and a fetch error beats a completion.
module dmac_run_fsm #(
    parameter int CMD_W    = 2,
    parameter int HALT_CMD = 1,
    parameter int STOP_CMD = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic                eff_en,
    input  logic                eff_cont,
    input  logic                eff_from_start,
    input  logic                eff_mem_ptr,
    input  logic                done_stb,
    input  logic [CMD_W-1:0]    done_cmd,
    input  logic                fetch_err,
    output dmac_pkg::run_state_e state_q,
    output logic                err_q,
    output logic                clr_en,
    output logic                clr_cont,
    output logic                start_nxt,
    output logic                adv_nxt,
    output logic                pause_nxt,
    output logic                done_nxt
);
    import dmac_pkg::*;

    localparam logic [CMD_W-1:0] HALT_V = CMD_W'(HALT_CMD);
    localparam logic [CMD_W-1:0] STOP_V = CMD_W'(STOP_CMD);

    run_state_e st_nxt;
    logic       err_nxt;

    // Next-state and request decode for one cycle.
    always_comb begin
        st_nxt    = state_q;
        err_nxt   = err_q;
        clr_en    = 1'b0;
        clr_cont  = 1'b0;
        start_nxt = 1'b0;
        adv_nxt   = 1'b0;
        pause_nxt = 1'b0;
        done_nxt  = 1'b0;
        if (wr) begin
            if (eff_en) begin
                err_nxt = 1'b0;
                if (state_q == RS_HOLD && eff_cont) begin
                    clr_cont = 1'b1;
                    st_nxt   = RS_RUN;
                    if (eff_from_start) start_nxt = 1'b1;
                    else                adv_nxt   = 1'b1;
                end else if (state_q == RS_OFF) begin
                    start_nxt = 1'b1;
                    st_nxt    = RS_RUN;
                end
            end else if (state_q == RS_HOLD && eff_cont) begin
                st_nxt = RS_OFF;
            end
        end else if (state_q == RS_RUN) begin
            if (fetch_err) begin
                err_nxt = 1'b1;
                st_nxt  = RS_OFF;
            end else if (done_stb) begin
                done_nxt = 1'b1;
                if (!eff_mem_ptr || done_cmd == STOP_V) begin
                    clr_en = 1'b1;
                    st_nxt = RS_OFF;
                end else if (done_cmd == HALT_V) begin
                    st_nxt    = RS_HOLD;
                    pause_nxt = 1'b1;
                end else begin
                    adv_nxt = 1'b1;
                end
            end
        end
    end

    // Hold the run state and the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_OFF;
            err_q   <= 1'b0;
        end else begin
            state_q <= st_nxt;
            err_q   <= err_nxt;
        end
    end
endmodule

// File: rtl/dmac_evt_reg.sv
// Output pulse register: one flop per request or event line.
// Assumes every input bit is already a single-cycle pulse.
module dmac_evt_reg #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Register one pulse line.
        always_ff @(posedge clk) begin
            if (!rst_n) q[i] <= 1'b0;
            else        q[i] <= d[i];
        end
    end
endmodule

// File: rtl/dmac_run_ctrl.sv
// Top of the DMA channel run-state controller.
// It joins the control-bit holder, the run-state machine and the pulse register.
// The error flag overrides the state code with value 3.
// Assumes each write and each engine strobe lasts a single cycle.
module dmac_run_ctrl #(
    parameter int CMD_W    = 2,
    parameter int HALT_CMD = 1,
    parameter int STOP_CMD = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_en,
    input  logic             cfg_cont,
    input  logic             cfg_from_start,
    input  logic             cfg_mem_ptr,
    input  logic             desc_done,
    input  logic [CMD_W-1:0] desc_cmd,
    input  logic             fetch_err,
    output logic [1:0]       state_code,
    output logic             chan_en,
    output logic             cont_pend,
    output logic             start_req,
    output logic             adv_req,
    output logic             pause_evt,
    output logic             done_evt
);
    import dmac_pkg::*;

    localparam int EVT_N = 4;

    logic       eff_en, eff_cont, eff_from_start, eff_mem_ptr;
    logic       clr_en, clr_cont;
    logic       start_nxt, adv_nxt, pause_nxt, done_nxt;
    logic       err_q;
    run_state_e state_q;
    logic [EVT_N-1:0] evt_q;

    dmac_cfg_bits u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr),
        .wr_en(cfg_en), .wr_cont(cfg_cont),
        .wr_from_start(cfg_from_start), .wr_mem_ptr(cfg_mem_ptr),
        .clr_en(clr_en), .clr_cont(clr_cont),
        .eff_en(eff_en), .eff_cont(eff_cont),
        .eff_from_start(eff_from_start), .eff_mem_ptr(eff_mem_ptr),
        .en_q(chan_en), .cont_q(cont_pend)
    );

    dmac_run_fsm #(.CMD_W(CMD_W), .HALT_CMD(HALT_CMD), .STOP_CMD(STOP_CMD)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr),
        .eff_en(eff_en), .eff_cont(eff_cont),
        .eff_from_start(eff_from_start), .eff_mem_ptr(eff_mem_ptr),
        .done_stb(desc_done), .done_cmd(desc_cmd), .fetch_err(fetch_err),
        .state_q(state_q), .err_q(err_q),
        .clr_en(clr_en), .clr_cont(clr_cont),
        .start_nxt(start_nxt), .adv_nxt(adv_nxt),
        .pause_nxt(pause_nxt), .done_nxt(done_nxt)
    );

    dmac_evt_reg #(.N(EVT_N)) u_evt (
        .clk(clk), .rst_n(rst_n),
        .d({done_nxt, pause_nxt, adv_nxt, start_nxt}),
        .q(evt_q)
    );

    // Present the status code and split the pulse vector.
    always_comb begin
        state_code = err_q ? ERR_CODE : state_q;
        start_req  = evt_q[0];
        adv_req    = evt_q[1];
        pause_evt  = evt_q[2];
        done_evt   = evt_q[3];
    end
endmodule

// File: rtl/dmac_run_ctrl_chk.sv
// Property checker for the run-state controller, bound to every instance.
// It observes only top-level ports.
module dmac_run_ctrl_chk #(
    parameter int CMD_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic             cfg_en,
    input logic             cfg_cont,
    input logic             fetch_err,
    input logic             desc_done,
    input logic [1:0]       state_code,
    input logic             cont_pend,
    input logic             start_req,
    input logic             adv_req,
    input logic             pause_evt,
    input logic             done_evt
);
    // R8: a pause event is seen together with the paused code
    a_r8_pause_state: assert property (@(posedge clk) disable iff (!rst_n)
        pause_evt |-> state_code == 2'd2);

    // R7: a done event follows a cycle in which the channel was enabled
    a_r7_done_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |-> $past(state_code) == 2'd1);

    // R4: a resume write clears continue and raises exactly one request
    a_r4_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_en && cfg_cont && state_code == 2'd2)
        |=> (state_code == 2'd1 && !cont_pend && $onehot0({start_req, adv_req})
             && (start_req || adv_req)));

    // R3: enabling from disabled or error starts the channel
    a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_en && (state_code == 2'd0 || state_code == 2'd3))
        |=> (start_req && state_code == 2'd1));

    // R10: a fetch error while enabled gives the error code
    a_r10_err_code: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr && fetch_err && state_code == 2'd1) |=> state_code == 2'd3);

    // R11: strobes in the disabled or error state change nothing
    a_r11_idle_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr && (state_code == 2'd0 || state_code == 2'd3))
        |=> ($stable(state_code) && !done_evt && !pause_evt && !adv_req && !start_req));
endmodule

bind dmac_run_ctrl dmac_run_ctrl_chk #(.CMD_W(CMD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
    .cfg_cont(cfg_cont), .fetch_err(fetch_err), .desc_done(desc_done),
    .state_code(state_code), .cont_pend(cont_pend), .start_req(start_req),
    .adv_req(adv_req), .pause_evt(pause_evt), .done_evt(done_evt)
);

// File: tb/dmac_run_ctrl_tb_top.sv
`timescale 1ns/1ps
module dmac_run_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 0, cfg_en = 0, cfg_cont = 0, cfg_from_start = 0, cfg_mem_ptr = 0;
    logic desc_done = 0;
    logic [1:0] desc_cmd = 0;
    logic fetch_err = 0;
    logic [1:0] state_code;
    logic chan_en, cont_pend, start_req, adv_req, pause_evt, done_evt;

    int n_tests = 0;
    int n_fail = 0;
    string cur_req = "R1";
    bit finished = 0;

    // reference model state
    int  m_st = 0;
    bit  m_err = 0, m_en = 0, m_cont = 0, m_cs = 0, m_mem = 0;
    bit  e_start = 0, e_adv = 0, e_pause = 0, e_done = 0;

    always #10 clk = ~clk;

    dmac_run_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
        .cfg_cont(cfg_cont), .cfg_from_start(cfg_from_start),
        .cfg_mem_ptr(cfg_mem_ptr), .desc_done(desc_done), .desc_cmd(desc_cmd),
        .fetch_err(fetch_err), .state_code(state_code), .chan_en(chan_en),
        .cont_pend(cont_pend), .start_req(start_req), .adv_req(adv_req),
        .pause_evt(pause_evt), .done_evt(done_evt)
    );

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        e_start = 0; e_adv = 0; e_pause = 0; e_done = 0;
        if (!rst_n) begin
            m_st = 0; m_err = 0; m_en = 0; m_cont = 0; m_cs = 0; m_mem = 0;
        end else if (cfg_wr) begin
            m_en = cfg_en; m_cont = cfg_cont; m_cs = cfg_from_start; m_mem = cfg_mem_ptr;
            if (m_en) begin
                m_err = 0;
                if (m_st == 2 && m_cont) begin
                    if (m_cs) e_start = 1; else e_adv = 1;
                    m_cont = 0; m_st = 1;
                end else if (m_st == 0) begin
                    e_start = 1; m_st = 1;
                end
            end else if (m_st == 2 && m_cont) m_st = 0;
        end else if (m_st == 1 && fetch_err) begin
            m_err = 1; m_st = 0;
        end else if (m_st == 1 && desc_done) begin
            e_done = 1;
            if (!m_mem || desc_cmd == 2) begin m_en = 0; m_st = 0; end
            else if (desc_cmd == 1) begin m_st = 2; e_pause = 1; end
            else e_adv = 1;
        end
    end

    // compare every output against the model away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            n_tests++;
            if (state_code !== (m_err ? 2'd3 : 2'(m_st)) || chan_en !== m_en ||
                cont_pend !== m_cont || start_req !== e_start || adv_req !== e_adv ||
                pause_evt !== e_pause || done_evt !== e_done) begin
                n_fail++;
                $display("FAIL %s cycle: got st=%0d en=%b cont=%b s=%b a=%b p=%b d=%b exp st=%0d en=%b cont=%b s=%b a=%b p=%b d=%b",
                    cur_req, state_code, chan_en, cont_pend, start_req, adv_req, pause_evt, done_evt,
                    m_err ? 3 : m_st, m_en, m_cont, e_start, e_adv, e_pause, e_done);
            end
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wr(input bit en, input bit cont, input bit cs, input bit mem);
        @(negedge clk);
        cfg_wr = 1; cfg_en = en; cfg_cont = cont; cfg_from_start = cs; cfg_mem_ptr = mem;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic dn(input int cmd);
        @(negedge clk);
        desc_done = 1; desc_cmd = 2'(cmd);
        @(negedge clk);
        desc_done = 0;
    endtask

    task automatic ferr();
        @(negedge clk);
        fetch_err = 1;
        @(negedge clk);
        fetch_err = 0;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cur_req = "R1";
        chk("R1 state", state_code, 0);
        chk("R1 outputs", {chan_en, cont_pend, start_req, adv_req, pause_evt, done_evt}, 0);

        cur_req = "R3"; wr(1, 0, 0, 1);
        chk("R3 start_req", start_req, 1); chk("R3 state", state_code, 1);
        cur_req = "R9"; dn(0);
        chk("R9 adv cmd0", adv_req, 1); chk("R9 state", state_code, 1);
        dn(3); chk("R9 adv cmd3", adv_req, 1);
        cur_req = "R8"; dn(1);
        chk("R8 pause_evt", pause_evt, 1); chk("R8 state", state_code, 2);
        cur_req = "R5"; wr(1, 0, 0, 1);
        chk("R5 stays paused", state_code, 2); chk("R5 no request", start_req | adv_req, 0);
        cur_req = "R4"; wr(1, 1, 0, 1);
        chk("R4 adv on resume", adv_req, 1); chk("R4 cont cleared", cont_pend, 0);
        chk("R4 state", state_code, 1);
        dn(1); wr(1, 1, 1, 1);
        chk("R4 start on resume", start_req, 1); chk("R4 no adv", adv_req, 0);
        cur_req = "R6"; dn(1); wr(0, 1, 0, 1);
        chk("R6 disabled", state_code, 0); chk("R6 cont kept", cont_pend, 1);
        chk("R6 no request", start_req | adv_req, 0);
        cur_req = "R3"; wr(1, 0, 0, 1); chk("R3 restart", start_req, 1);
        cur_req = "R7"; dn(2);
        chk("R7 done_evt stop", done_evt, 1); chk("R7 en cleared", chan_en, 0);
        chk("R7 disabled", state_code, 0);
        wr(1, 0, 0, 0); dn(0);
        chk("R7 reg mode done", done_evt, 1); chk("R7 reg mode off", state_code, 0);
        cur_req = "R11"; dn(0);
        chk("R11 no done when off", done_evt, 0); chk("R11 state", state_code, 0);
        ferr(); chk("R11 err ignored when off", state_code, 0);
        cur_req = "R10"; wr(1, 0, 0, 1);
        @(negedge clk); desc_done = 1; fetch_err = 1; desc_cmd = 0;
        @(negedge clk); desc_done = 0; fetch_err = 0;
        chk("R10 error code", state_code, 3); chk("R10 error beats done", done_evt, 0);
        cur_req = "R11"; dn(0); chk("R11 ignored in error", done_evt, 0);
        cur_req = "R2"; wr(1, 0, 0, 1);
        chk("R2 error cleared", state_code, 1); chk("R2 start", start_req, 1);
        cur_req = "R12"; wr(1, 0, 0, 1);
        chk("R12 no request", start_req | adv_req, 0); chk("R12 state", state_code, 1);
        cur_req = "R11";
        @(negedge clk); cfg_wr = 1; cfg_en = 1; cfg_mem_ptr = 1; desc_done = 1; desc_cmd = 2;
        @(negedge clk); cfg_wr = 0; desc_done = 0;
        chk("R11 done dropped in write cycle", done_evt, 0); chk("R11 still on", state_code, 1);
        repeat (3) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule